// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of one conditional-branch instruction for a 32-bit processor. A valid strobe presents the instruction word, the address the instruction was fetched from, the condition register and the count register. The unit decodes the five-bit option field and the condition-bit index. It optionally decrements the count register and tests it, and optionally tests one condition-register bit. One cycle after the strobe it reports whether the branch is taken, the target address, a count write-back, a link write-back, an invalid-form flag and a two-bit hint.

Instruction bits are numbered 0 (most significant) to 31 (least significant). Bits 0-5 hold the primary opcode, which must be 16. Bits 6-10 hold the option field, named o0..o4 from the most significant bit down. Bits 11-15 hold the condition-bit index and bits 16-29 a signed word displacement. Bit 30 selects absolute targeting and bit 31 requests a link write. A two-bit mode input selects how the spare option bits are read: 00 is strict, 01 is hinted, and 10 or 11 is permissive. The unit never touches condition-register field 0 or the fixed-point exception register. It has no outputs for them.

Top module: `branch_resolve_unit`

## Requirements
- R1: All outputs are registered and appear on the clock edge after the strobe. `resolved_o` is 1 only when the strobe was high and bits 0-5 equalled 16. While `resolved_o` is 0, `taken_o`, `ctr_we_o`, `lr_we_o` and `invalid_o` are 0 and `hint_o` is 00.
- R2: With bit 30 equal to 0, the target is the instruction address plus the displacement. The displacement is shifted left by two and sign-extended to 32 bits, so it can be negative.
- R3: With bit 30 equal to 1, the target is the shifted, sign-extended displacement alone, including negative values.
- R4: With bit 31 equal to 1 on a valid form, `lr_we_o` is 1 and `lr_o` equals the instruction address plus 4. With bit 31 equal to 0, `lr_we_o` is 0.
- R5: When o2 is 0, `ctr_we_o` is 1 and `ctr_o` is the count minus one, whether or not the branch is taken. A count of 0 wraps to 0xFFFFFFFF. When o2 is 1, `ctr_we_o` is 0.
- R6: When o2 is 0, the count test passes on a nonzero decremented count if o3 is 0, and on a zero decremented count if o3 is 1. When o2 is 1, the count test always passes.
- R7: When o0 is 0, the condition test passes only if the condition-register bit selected by the index equals o1. Index k selects register bit `cr_i[31-k]`. When o0 is 1, the condition test always passes.
- R8: `taken_o` is 1 exactly when both tests pass on a valid form. The option pattern 1z1zz always branches, with no decrement.
- R9: In strict mode, the form is invalid if any reserved-zero bit is 1. These bits are o3 when o0=0 and o2=1; o1 when o0=1 and o2=0; and o1, o3 and o4 when o0=1 and o2=1. An invalid form sets `invalid_o` and forces `taken_o`, `ctr_we_o` and `lr_we_o` to 0.
- R10: In hinted mode, `hint_o` is {o3,o4} when o0=0 and o2=1, and {o1,o4} when o0=1 and o2=0. The reserved value 01 is reported as 00. All other forms report 00.
- R11: In permissive mode (mode 10 or 11), no form is invalid and `hint_o` is 00. Strict mode also reports hint 00.
- R12: Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word (bit 0 = insn_i[31]) |
| pc_i | input | 32 | Address of the instruction |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 32 | Count register |
| mode_i | input | 2 | 00 strict, 01 hinted, 10/11 permissive |
| resolved_o | output | 1 | A branch was resolved last cycle |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | Branch target address |
| ctr_we_o | output | 1 | Count register write enable |
| ctr_o | output | 32 | Decremented count value |
| lr_we_o | output | 1 | Link register write enable |
| lr_o | output | 32 | Return address |
| invalid_o | output | 1 | Invalid form in strict mode |
| hint_o | output | 2 | Prediction hint: 00 none, 10 unlikely, 11 likely |

## Verification
The hardest situation to reach is a strict-mode form that would otherwise be taken and request a link write, but carries a set reserved-zero bit. Reaching it requires the mode, the option pattern, the condition bit and the link bit to agree in a single instruction. The vector table builds exactly such words, so the suppression of every write can be observed. It then replays the same word in permissive mode to show that the branch is taken there. Count wrap is reached by presenting a count of zero with a decrementing option, which exposes the all-ones write-back.

// File: rtl/brp_pkg.sv
package brp_pkg;

    localparam int XLEN     = 32;
    localparam int DISP_W   = 14;
    localparam int IDX_W    = 5;
    localparam int OPC_W    = 6;
    localparam int OPT_W    = 5;
    localparam logic [OPC_W-1:0] BRANCH_OPC = OPC_W'(16);
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        MODE_STRICT = 2'b00,
        MODE_HINTED = 2'b01,
        MODE_LOOSE  = 2'b10,
        MODE_LOOSE2 = 2'b11
    } mode_e;

    // option field, most significant bit first (o0..o4)
    typedef struct packed {
        logic skip_cond;   // o0
        logic want_set;    // o1
        logic skip_ctr;    // o2
        logic on_zero;     // o3
        logic low;         // o4
    } opt_t;

    typedef struct packed {
        logic              opc_ok;
        opt_t              opt;
        logic [IDX_W-1:0]  bit_idx;
        logic [DISP_W-1:0] disp;
        logic              absolute;
        logic              link;
    } fields_t;

    typedef struct packed {
        logic            dec_en;
        logic [XLEN-1:0] dec_val;
        logic            ctr_ok;
        logic            cond_ok;
    } test_t;

    typedef struct packed {
        logic            resolved;
        logic            taken;
        logic            invalid;
        logic [1:0]      hint;
        logic [XLEN-1:0] target;
        logic            ctr_we;
        logic [XLEN-1:0] ctr;
        logic            lr_we;
        logic [XLEN-1:0] lr;
    } result_t;

    function automatic logic [XLEN-1:0] sext_disp(input logic [DISP_W-1:0] d);
        logic [DISP_W+1:0] w;
        w = {d, 2'b00};
        return {{(XLEN-DISP_W-2){w[DISP_W+1]}}, w};
    endfunction

    // index 0 names the most significant register bit
    function automatic logic cr_pick(input logic [XLEN-1:0] cr,
                                     input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] pos;
        pos = IDX_W'(XLEN - 1) - idx;
        return cr[pos];
    endfunction

    function automatic logic strict_bad(input opt_t o);
        logic bad;
        unique case ({o.skip_cond, o.skip_ctr})
            2'b00:   bad = 1'b0;
            2'b01:   bad = o.on_zero;
            2'b10:   bad = o.want_set;
            default: bad = o.want_set | o.on_zero | o.low;
        endcase
        return bad;
    endfunction

    function automatic logic [1:0] hint_of(input opt_t o);
        logic [1:0] raw;
        unique case ({o.skip_cond, o.skip_ctr})
            2'b01:   raw = {o.on_zero, o.low};
            2'b10:   raw = {o.want_set, o.low};
            default: raw = 2'b00;
        endcase
        return (raw == 2'b01) ? 2'b00 : raw;
    endfunction

endpackage

// File: rtl/brp_decode.sv
module brp_decode
    import brp_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output fields_t         f
);
    localparam int OPC_LO  = XLEN - OPC_W;
    localparam int OPT_LO  = OPC_LO - OPT_W;
    localparam int IDX_LO  = OPT_LO - IDX_W;
    localparam int DISP_LO = IDX_LO - DISP_W;

    always_comb begin
        f.opc_ok   = (insn[XLEN-1:OPC_LO] == BRANCH_OPC);
        f.opt      = opt_t'(insn[OPC_LO-1:OPT_LO]);
        f.bit_idx  = insn[OPT_LO-1:IDX_LO];
        f.disp     = insn[IDX_LO-1:DISP_LO];
        f.absolute = insn[1];
        f.link     = insn[0];
    end
endmodule

// File: rtl/brp_test.sv
module brp_test
    import brp_pkg::*;
(
    input  fields_t         f,
    input  logic [XLEN-1:0] cr,
    input  logic [XLEN-1:0] ctr,
    output test_t           t
);
    logic dec_is_zero;

    // compare the input against one instead of the decremented value
    assign dec_is_zero = (ctr == XLEN'(1));

    always_comb begin
        t.dec_en  = ~f.opt.skip_ctr;
        t.dec_val = ctr - XLEN'(1);
        if (f.opt.skip_ctr)
            t.ctr_ok = 1'b1;
        else
            t.ctr_ok = f.opt.on_zero ? dec_is_zero : ~dec_is_zero;
        if (f.opt.skip_cond)
            t.cond_ok = 1'b1;
        else
            t.cond_ok = (cr_pick(cr, f.bit_idx) == f.opt.want_set);
    end
endmodule

// File: rtl/brp_form.sv
module brp_form
    import brp_pkg::*;
(
    input  opt_t       opt,
    input  mode_e      mode,
    output logic       bad,
    output logic [1:0] hint
);
    always_comb begin
        bad  = 1'b0;
        hint = 2'b00;
        unique case (mode)
            MODE_STRICT: bad  = strict_bad(opt);
            MODE_HINTED: hint = hint_of(opt);
            default: ;
        endcase
    end
endmodule

// File: rtl/brp_target.sv
module brp_target
    import brp_pkg::*;
(
    input  fields_t         f,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] ret_addr
);
    logic [XLEN-1:0] offs;
    logic [XLEN-1:0] base;

    assign offs     = sext_disp(f.disp);
    assign base     = f.absolute ? '0 : pc;
    assign target   = base + offs;
    assign ret_addr = pc + XLEN'(INSN_BYTES);
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import brp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic [31:0] insn_i,
    input  logic [31:0] pc_i,
    input  logic [31:0] cr_i,
    input  logic [31:0] ctr_i,
    input  logic [1:0]  mode_i,
    output logic        resolved_o,
    output logic        taken_o,
    output logic [31:0] target_o,
    output logic        ctr_we_o,
    output logic [31:0] ctr_o,
    output logic        lr_we_o,
    output logic [31:0] lr_o,
    output logic        invalid_o,
    output logic [1:0]  hint_o
);
    fields_t         fld;
    test_t           tst;
    logic            bad;
    logic [1:0]      hint;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] ret_addr;
    logic            accept;
    logic            live;
    result_t         res_d;
    result_t         res_q;

    brp_decode u_dec (.insn(insn_i), .f(fld));

    brp_test u_tst (.f(fld), .cr(cr_i), .ctr(ctr_i), .t(tst));

    brp_form u_form (
        .opt  (fld.opt),
        .mode (mode_e'(mode_i)),
        .bad  (bad),
        .hint (hint)
    );

    brp_target u_tgt (
        .f        (fld),
        .pc       (pc_i),
        .target   (target),
        .ret_addr (ret_addr)
    );

    assign accept = valid_i & fld.opc_ok;
    assign live   = accept & ~bad;

    always_comb begin
        res_d.resolved = accept;
        res_d.invalid  = accept & bad;
        res_d.taken    = live & tst.ctr_ok & tst.cond_ok;
        res_d.hint     = accept ? hint : 2'b00;
        res_d.target   = target;
        res_d.ctr_we   = live & tst.dec_en;
        res_d.ctr      = tst.dec_val;
        res_d.lr_we    = live & fld.link;
        res_d.lr       = ret_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign resolved_o = res_q.resolved;
    assign taken_o    = res_q.taken;
    assign target_o   = res_q.target;
    assign ctr_we_o   = res_q.ctr_we;
    assign ctr_o      = res_q.ctr;
    assign lr_we_o    = res_q.lr_we;
    assign lr_o       = res_q.lr;
    assign invalid_o  = res_q.invalid;
    assign hint_o     = res_q.hint;
endmodule

// File: rtl/branch_resolve_unit_chk.sv
module branch_resolve_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [31:0] insn_i,
    input logic [31:0] pc_i,
    input logic [31:0] ctr_i,
    input logic [1:0]  mode_i,
    input logic        resolved_o,
    input logic        taken_o,
    input logic        ctr_we_o,
    input logic [31:0] ctr_o,
    input logic        lr_we_o,
    input logic [31:0] lr_o,
    input logic        invalid_o,
    input logic [1:0]  hint_o
);
    a_r1_no_strobe_no_result: assert property (@(posedge clk) disable iff (rst)
        !$past(valid_i) |-> !resolved_o);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !resolved_o |-> !(taken_o || ctr_we_o || lr_we_o || invalid_o) && hint_o == 2'b00);

    a_r4_link_value: assert property (@(posedge clk) disable iff (rst)
        lr_we_o |-> lr_o == $past(pc_i) + 32'd4);

    a_r5_count_value: assert property (@(posedge clk) disable iff (rst)
        ctr_we_o |-> ctr_o == $past(ctr_i) - 32'd1);

    a_r5_count_we_follows_o2: assert property (@(posedge clk) disable iff (rst)
        (resolved_o && !invalid_o) |-> ctr_we_o == !$past(insn_i[23]));

    a_r9_invalid_silences: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> !taken_o && !ctr_we_o && !lr_we_o);

    a_r9_invalid_only_strict: assert property (@(posedge clk) disable iff (rst)
        invalid_o |-> $past(mode_i) == 2'b00);

    a_r10_hint_only_hinted: assert property (@(posedge clk) disable iff (rst)
        hint_o != 2'b00 |-> $past(mode_i) == 2'b01);

    a_r10_no_reserved_hint: assert property (@(posedge clk) disable iff (rst)
        hint_o != 2'b01);
endmodule

bind branch_resolve_unit branch_resolve_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .insn_i     (insn_i),
    .pc_i       (pc_i),
    .ctr_i      (ctr_i),
    .mode_i     (mode_i),
    .resolved_o (resolved_o),
    .taken_o    (taken_o),
    .ctr_we_o   (ctr_we_o),
    .ctr_o      (ctr_o),
    .lr_we_o    (lr_we_o),
    .lr_o       (lr_o),
    .invalid_o  (invalid_o),
    .hint_o     (hint_o)
);

// File: tb/sim_branch_resolve_unit.sv
`timescale 1ns/1ps
module sim_branch_resolve_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [31:0] pc_i = '0;
    logic [31:0] cr_i = '0;
    logic [31:0] ctr_i = '0;
    logic [1:0]  mode_i = '0;
    logic        resolved_o, taken_o, ctr_we_o, lr_we_o, invalid_o;
    logic [31:0] target_o, ctr_o, lr_o;
    logic [1:0]  hint_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    branch_resolve_unit u0 (.*);

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] insn;
        logic [31:0] pc;
        logic [31:0] cr;
        logic [31:0] ctr;
        logic        taken;
        logic [31:0] target;
        logic        ctr_we;
        logic [31:0] ctr_new;
        logic        lr_we;
        logic        invalid;
        logic [1:0]  hint;
    } vec_t;

    localparam int NV = 16;
    // insn = {opcode 16, option o0..o4, index, disp, abs, link}
    localparam vec_t VECS [NV] = '{
        // 0: R7 R8 R2 condition true on bit 0 (LT), no decrement
        '{2'b10, {6'd16,5'b01100,5'd0,14'h0010,1'b0,1'b0}, 32'h1000, 32'h8000_0000, 32'd5,
          1'b1, 32'h1040, 1'b0, 32'd0, 1'b0, 1'b0, 2'b00},
        // 1: R7 same word, bit clear -> not taken
        '{2'b10, {6'd16,5'b01100,5'd0,14'h0010,1'b0,1'b0}, 32'h1000, 32'h0, 32'd5,
          1'b0, 32'h1040, 1'b0, 32'd0, 1'b0, 1'b0, 2'b00},
        // 2: R6 R5 R4 R2 decrement to nonzero, index 2 set, negative displacement, link
        '{2'b10, {6'd16,5'b01000,5'd2,14'h3FFF,1'b0,1'b1}, 32'h2000, 32'h2000_0000, 32'd3,
          1'b1, 32'h1FFC, 1'b1, 32'd2, 1'b1, 1'b0, 2'b00},
        // 3: R6 R3 branch on decremented zero, absolute, strict and valid
        '{2'b00, {6'd16,5'b10010,5'd0,14'h0100,1'b1,1'b0}, 32'h4000, 32'h0, 32'd1,
          1'b1, 32'h0000_0400, 1'b1, 32'd0, 1'b0, 1'b0, 2'b00},
        // 4: R5 R3 count 0 wraps, negative absolute target
        '{2'b10, {6'd16,5'b10000,5'd0,14'h2000,1'b1,1'b0}, 32'h4000, 32'h0, 32'd0,
          1'b1, 32'hFFFF_8000, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'b00},
        // 5: R5 R6 decrement written back even when count test fails
        '{2'b10, {6'd16,5'b00000,5'd0,14'h0000,1'b0,1'b0}, 32'h5000, 32'h0, 32'd1,
          1'b0, 32'h5000, 1'b1, 32'd0, 1'b0, 1'b0, 2'b00},
        // 6: R8 branch always, no decrement, strict valid
        '{2'b00, {6'd16,5'b10100,5'd0,14'h0001,1'b0,1'b0}, 32'h3000, 32'h0, 32'd0,
          1'b1, 32'h3004, 1'b0, 32'd0, 1'b0, 1'b0, 2'b00},
        // 7: R9 always-form with set o3 under strict: invalid, link suppressed
        '{2'b00, {6'd16,5'b10110,5'd0,14'h0002,1'b0,1'b1}, 32'h6000, 32'h0, 32'd0,
          1'b0, 32'h6008, 1'b0, 32'd0, 1'b0, 1'b1, 2'b00},
        // 8: R9 condition-false form with set o3 under strict: would be taken
        '{2'b00, {6'd16,5'b00110,5'd0,14'h1FFF,1'b0,1'b1}, 32'h7000, 32'h0, 32'd0,
          1'b0, 32'hEFFC, 1'b0, 32'd0, 1'b0, 1'b1, 2'b00},
        // 9: R11 same word permissive: taken with link
        '{2'b10, {6'd16,5'b00110,5'd0,14'h1FFF,1'b0,1'b1}, 32'h7000, 32'h0, 32'd0,
          1'b1, 32'hEFFC, 1'b0, 32'd0, 1'b1, 1'b0, 2'b00},
        // 10: R10 hinted, condition-only, hint 11
        '{2'b01, {6'd16,5'b01111,5'd0,14'h0004,1'b0,1'b0}, 32'h100, 32'h8000_0000, 32'd0,
          1'b1, 32'h110, 1'b0, 32'd0, 1'b0, 1'b0, 2'b11},
        // 11: R10 hinted, condition-false, hint 10
        '{2'b01, {6'd16,5'b00110,5'd0,14'h0004,1'b0,1'b0}, 32'h100, 32'h0, 32'd0,
          1'b1, 32'h110, 1'b0, 32'd0, 1'b0, 1'b0, 2'b10},
        // 12: R10 R7 reserved hint 01 -> 00, index 31 picks the lowest register bit
        '{2'b01, {6'd16,5'b01101,5'd31,14'h0004,1'b0,1'b0}, 32'h100, 32'h1, 32'd0,
          1'b1, 32'h110, 1'b0, 32'd0, 1'b0, 1'b0, 2'b00},
        // 13: R10 hinted, count-only form takes hint {o1,o4}
        '{2'b01, {6'd16,5'b11001,5'd0,14'h0040,1'b1,1'b0}, 32'h100, 32'h0, 32'd5,
          1'b1, 32'h100, 1'b1, 32'd4, 1'b0, 1'b0, 2'b11},
        // 14: R10 hinted, always form gives no hint
        '{2'b01, {6'd16,5'b10100,5'd0,14'h0004,1'b0,1'b0}, 32'h100, 32'h0, 32'd0,
          1'b1, 32'h110, 1'b0, 32'd0, 1'b0, 1'b0, 2'b00},
        // 15: R9 always-form with set o4 under strict is invalid
        '{2'b00, {6'd16,5'b10101,5'd0,14'h0004,1'b0,1'b0}, 32'h100, 32'h0, 32'd0,
          1'b0, 32'h110, 1'b0, 32'd0, 1'b0, 1'b1, 2'b00}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic [31:0] w, input logic [31:0] pc,
                         input logic [31:0] cr, input logic [31:0] ct);
        @(negedge clk);
        valid_i = 1'b1; mode_i = m; insn_i = w; pc_i = pc; cr_i = cr; ctr_i = ct;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " resolved"}, 32'(resolved_o), 32'd0);
        chk({tag, " enables"}, {29'd0, taken_o, ctr_we_o, lr_we_o}, 32'd0);
        chk({tag, " invalid/hint"}, {29'd0, invalid_o, hint_o}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk_idle("R12 reset");
        chk("R12 reset target", target_o, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tg;
            v = VECS[i];
            tg = $sformatf("vec%0d", i);
            issue(v.mode, v.insn, v.pc, v.cr, v.ctr);
            chk({tg, " R1 resolved"}, 32'(resolved_o), 32'd1);
            chk({tg, " R8 taken"}, 32'(taken_o), 32'(v.taken));
            chk({tg, " R2/R3 target"}, target_o, v.target);
            chk({tg, " R5 ctr_we"}, 32'(ctr_we_o), 32'(v.ctr_we));
            if (v.ctr_we) chk({tg, " R5 ctr value"}, ctr_o, v.ctr_new);
            chk({tg, " R4 lr_we"}, 32'(lr_we_o), 32'(v.lr_we));
            if (v.lr_we) chk({tg, " R4 lr value"}, lr_o, v.pc + 32'd4);
            chk({tg, " R9 invalid"}, 32'(invalid_o), 32'(v.invalid));
            chk({tg, " R10 hint"}, 32'(hint_o), 32'(v.hint));
        end

        // R1: strobe low on the following cycle gives nothing
        @(negedge clk);
        chk_idle("R1 no strobe");

        // R1: wrong opcode with decrement and link requested
        issue(2'b10, {6'd18,5'b10000,5'd0,14'h0004,1'b0,1'b1}, 32'h100, 32'h0, 32'd5);
        chk_idle("R1 bad opcode");

        // R11: mode 11 behaves as permissive
        issue(2'b11, {6'd16,5'b00110,5'd0,14'h0004,1'b0,1'b0}, 32'h100, 32'h0, 32'd0);
        chk("R11 mode3 invalid", 32'(invalid_o), 32'd0);
        chk("R11 mode3 taken", 32'(taken_o), 32'd1);
        chk("R11 mode3 hint", 32'(hint_o), 32'd0);

        // R12: reset right after a strobe clears the result
        @(negedge clk);
        valid_i = 1'b1; mode_i = 2'b10; pc_i = 32'h100; cr_i = 32'h0; ctr_i = 32'd3;
        insn_i = {6'd16,5'b10000,5'd0,14'h0004,1'b0,1'b1};
        rst = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        chk_idle("R12 mid reset");
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule